// File: doc/BRIEF.md
# Instruction Class Decoder with Effective-Address Resolver

This block is a small clocked sequencer. It takes one 16-bit instruction word, sorts it into one of three classes and works out the operand address. The word carries an indirect flag in bit 15, an opcode in bits 14..12 and an address field in bits 11..0. Opcode values 0 to 6 refer to memory. Opcode 7 is a register operation when the flag is clear, and an input-output operation when the flag is set.

For a memory instruction with the flag clear, the address field is the effective address. With the flag set, the sequencer makes one read on a synchronous 4096 x 16 memory port, and the low 12 bits of the returned word become the effective address. The memory returns data one cycle after the read is issued.

A controller pulses `start` while the unit is idle. The results stay on the outputs, and a one-cycle `done` pulse marks the cycle in which they become valid. Executing the instruction is left to the rest of the machine.

Top module: `insn_ea_unit`

## Requirements
- R1: While reset is held and after its release, before any instruction: `done`, `mem_rd_en`, `opcode_out`, `class_out`, `ea_out` and `op_field` are all 0.
- R2: `opcode_out` is bits 14..12 of the accepted word. `class_out` is 2'b00 (memory) for opcodes 0..6, 2'b01 (register) for opcode 7 with bit 15 clear, and 2'b10 (input-output) for opcode 7 with bit 15 set.
- R3: For a memory instruction with bit 15 clear, `ea_out` equals bits 11..0 and no memory read is issued. `done` is high in the second cycle after the clock edge that accepts `start`.
- R4: For a memory instruction with bit 15 set, exactly one read is issued, in the first cycle after acceptance, with `mem_addr` equal to bits 11..0. `ea_out` equals bits 11..0 of the returned word, and `done` is high in the third cycle after acceptance.
- R5: For register and input-output instructions, `ea_out` is 0, `op_field` equals bits 11..0, and no memory read is issued. For memory instructions, `op_field` is 0.
- R6: `done` is high for exactly one cycle per accepted instruction.
- R7: `start` is accepted only while the unit is idle. A `start` raised while an instruction is in progress, including in the cycle `done` is high, is ignored.
- R8: `opcode_out`, `class_out`, `ea_out` and `op_field` change only in the cycle `done` is high, and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Accept `insn_word` when idle |
| insn_word | input | 16 | Instruction word: flag bit 15, opcode 14..12, address 11..0 |
| mem_rd_en | output | 1 | Memory read request for the indirect fetch |
| mem_addr | output | 12 | Memory address for the read |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd_en` |
| opcode_out | output | 3 | Decoded opcode |
| class_out | output | 2 | 00 memory, 01 register, 10 input-output |
| ea_out | output | 12 | Effective address, 0 for non-memory classes |
| op_field | output | 12 | Operation field for register and I/O classes, else 0 |
| done | output | 1 | One-cycle completion strobe |

## Verification
Two events can land in the same cycle: a new `start` request and an instruction still in flight. The worst case is a request that arrives while the indirect read data returns, or while `done` is high. To provoke this, the bench holds `start` high with a different word through the whole decode, read and completion cycles of an indirect instruction. It then judges that exactly one `done` appears, that it carries the first word's results, and that no second completion follows. A full sweep over every flag and opcode combination, with edge-case address fields, checks the class, the effective address and the strobe timing against values the bench computes itself.

// File: rtl/insn_ea_pkg.sv
package insn_ea_pkg;

  typedef enum logic [1:0] {
    CLS_MEM = 2'b00,
    CLS_REG = 2'b01,
    CLS_IO  = 2'b10
  } insn_cls_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_DECODE = 2'b01,
    ST_IND_RD = 2'b10,
    ST_DONE   = 2'b11
  } seq_st_e;

endpackage

// File: rtl/insn_field_dec.sv
module insn_field_dec
  import insn_ea_pkg::*;
#(
  parameter int OPC_W  = 3,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 1 + OPC_W + ADDR_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] addr,
  output insn_cls_e         cls,
  output logic              need_ind
);

  localparam logic [OPC_W-1:0] OPC_ALL = {OPC_W{1'b1}};

  logic flag;

  always_comb begin
    flag   = word[WORD_W-1];
    opcode = word[WORD_W-2 -: OPC_W];
    addr   = word[ADDR_W-1:0];
    if (opcode != OPC_ALL) begin
      cls = CLS_MEM;
    end else if (flag) begin
      cls = CLS_IO;
    end else begin
      cls = CLS_REG;
    end
    need_ind = (cls == CLS_MEM) && flag;
  end

endmodule

// File: rtl/insn_ea_seq.sv
module insn_ea_seq
  import insn_ea_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_ind,
  output logic ld_ir,
  output logic rd_en,
  output logic commit_dir,
  output logic commit_ind,
  output logic done
);

  seq_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    ld_ir      = 1'b0;
    rd_en      = 1'b0;
    commit_dir = 1'b0;
    commit_ind = 1'b0;
    done       = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          ld_ir = 1'b1;
          st_d  = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (need_ind) begin
          rd_en = 1'b1;
          st_d  = ST_IND_RD;
        end else begin
          commit_dir = 1'b1;
          st_d       = ST_DONE;
        end
      end
      ST_IND_RD: begin
        commit_ind = 1'b1;
        st_d       = ST_DONE;
      end
      ST_DONE: begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/insn_ea_regs.sv
module insn_ea_regs
  import insn_ea_pkg::*;
#(
  parameter int OPC_W  = 3,
  parameter int ADDR_W = 12,
  parameter int WORD_W = 1 + OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ir,
  input  logic [WORD_W-1:0] insn_word,
  output logic [WORD_W-1:0] ir_q,
  input  logic              commit_dir,
  input  logic              commit_ind,
  input  logic [OPC_W-1:0]  dec_opcode,
  input  insn_cls_e         dec_cls,
  input  logic [ADDR_W-1:0] dec_addr,
  input  logic [ADDR_W-1:0] rd_low,
  output logic [OPC_W-1:0]  opcode_q,
  output logic [1:0]        cls_q,
  output logic [ADDR_W-1:0] ea_q,
  output logic [ADDR_W-1:0] opf_q
);

  logic              res_en;
  logic [OPC_W-1:0]  opcode_d;
  logic [1:0]        cls_d;
  logic [ADDR_W-1:0] ea_d;
  logic [ADDR_W-1:0] opf_d;

  always_comb begin
    res_en   = commit_dir | commit_ind;
    opcode_d = dec_opcode;
    cls_d    = dec_cls;
    if (commit_ind) begin
      ea_d  = rd_low;
      opf_d = '0;
    end else if (dec_cls == CLS_MEM) begin
      ea_d  = dec_addr;
      opf_d = '0;
    end else begin
      ea_d  = '0;
      opf_d = dec_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0;
    end else if (ld_ir) begin
      ir_q <= insn_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0;
      cls_q    <= '0;
      ea_q     <= '0;
      opf_q    <= '0;
    end else if (res_en) begin
      opcode_q <= opcode_d;
      cls_q    <= cls_d;
      ea_q     <= ea_d;
      opf_q    <= opf_d;
    end
  end

endmodule

// File: rtl/insn_ea_unit.sv
module insn_ea_unit
  import insn_ea_pkg::*;
#(
  parameter int OPC_W  = 3,
  parameter int ADDR_W = 12,
  localparam int WORD_W = 1 + OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] insn_word,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [OPC_W-1:0]  opcode_out,
  output logic [1:0]        class_out,
  output logic [ADDR_W-1:0] ea_out,
  output logic [ADDR_W-1:0] op_field,
  output logic              done
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [WORD_W-1:0] ir_q;
  logic [OPC_W-1:0]  dec_opcode;
  logic [ADDR_W-1:0] dec_addr;
  insn_cls_e         dec_cls;
  logic              need_ind;
  logic              ld_ir, commit_dir, commit_ind;
  logic              unused_rdata_hi;

  assign unused_rdata_hi = ^mem_rdata[WORD_W-1:ADDR_W];

  insn_field_dec #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dec (
    .word     (ir_q),
    .opcode   (dec_opcode),
    .addr     (dec_addr),
    .cls      (dec_cls),
    .need_ind (need_ind)
  );

  insn_ea_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .need_ind   (need_ind),
    .ld_ir      (ld_ir),
    .rd_en      (mem_rd_en),
    .commit_dir (commit_dir),
    .commit_ind (commit_ind),
    .done       (done)
  );

  insn_ea_regs #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ld_ir      (ld_ir),
    .insn_word  (insn_word),
    .ir_q       (ir_q),
    .commit_dir (commit_dir),
    .commit_ind (commit_ind),
    .dec_opcode (dec_opcode),
    .dec_cls    (dec_cls),
    .dec_addr   (dec_addr),
    .rd_low     (mem_rdata[ADDR_W-1:0]),
    .opcode_q   (opcode_out),
    .cls_q      (class_out),
    .ea_q       (ea_out),
    .opf_q      (op_field)
  );

  assign mem_addr = dec_addr;

endmodule

// File: rtl/insn_ea_unit_chk.sv
module insn_ea_unit_chk #(
  parameter int OPC_W  = 3,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              mem_rd_en,
  input logic [OPC_W-1:0]  opcode_out,
  input logic [1:0]        class_out,
  input logic [ADDR_W-1:0] ea_out,
  input logic [ADDR_W-1:0] op_field,
  input logic              done
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> !done);

  // R4
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_rd_en |=> !mem_rd_en);

  // R4
  read_to_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_rd_en |-> ##2 done);

  // R5
  nonmem_ea_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (done && class_out != 2'b00) |-> (ea_out == '0));

  // R2
  class_opcode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> ((class_out == 2'b00) == (opcode_out != {OPC_W{1'b1}})));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> ($stable(ea_out) && $stable(op_field) && $stable(class_out) && $stable(opcode_out)));

endmodule

bind insn_ea_unit insn_ea_unit_chk #(.OPC_W(OPC_W), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .mem_rd_en  (mem_rd_en),
  .opcode_out (opcode_out),
  .class_out  (class_out),
  .ea_out     (ea_out),
  .op_field   (op_field),
  .done       (done)
);

// File: tb/insn_ea_unit_test.sv
module insn_ea_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] insn_word = '0;
  logic        mem_rd_en;
  logic [11:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic [2:0]  opcode_out;
  logic [1:0]  class_out;
  logic [11:0] ea_out;
  logic [11:0] op_field;
  logic        done;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_ea_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .insn_word  (insn_word),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr),
    .mem_rdata  (mem_rdata),
    .opcode_out (opcode_out),
    .class_out  (class_out),
    .ea_out     (ea_out),
    .op_field   (op_field),
    .done       (done)
  );

  function automatic logic [15:0] word_at(input logic [11:0] a);
    logic [11:0] lo;
    lo = 12'(int'(a) * 77 + 291);
    return {4'hA ^ a[3:0], lo};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= word_at(mem_addr);
  end

  function automatic logic [11:0] addr_pick(input int i);
    case (i)
      0: return 12'h000;
      1: return 12'hFFF;
      2: return 12'h5A5;
      default: return 12'h0C3;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_insn(input logic [15:0] w, input bit collide);
    logic        fl;
    logic [2:0]  opc;
    logic [11:0] a;
    bit          is_mem, ind;
    int          e_cls, e_ea, e_opf, e_k;
    int          done_cnt, done_k, rd_cnt, rd_k, rd_a;
    int          c_opc, c_cls, c_ea, c_opf;
    fl = w[15]; opc = w[14:12]; a = w[11:0];
    is_mem = (opc != 3'b111);
    ind    = is_mem && fl;
    e_cls  = is_mem ? 0 : (fl ? 2 : 1);
    e_ea   = !is_mem ? 0 : (ind ? int'(word_at(a) & 16'h0FFF) : int'(a));
    e_opf  = is_mem ? 0 : int'(a);
    e_k    = ind ? 2 : 1;
    done_cnt = 0; done_k = -1; rd_cnt = 0; rd_k = -1; rd_a = -1;
    c_opc = -1; c_cls = -1; c_ea = -1; c_opf = -1;

    @(negedge clk);
    insn_word = w;
    start = 1'b1;
    @(negedge clk);
    if (collide) begin
      insn_word = ~w;
      start = 1'b1;
    end else begin
      start = 1'b0;
    end
    for (int k = 0; k < 7; k++) begin
      if (collide && k == 3) start = 1'b0;
      if (mem_rd_en) begin rd_cnt++; rd_k = k; rd_a = int'(mem_addr); end
      if (done) begin
        done_cnt++; done_k = k;
        c_opc = int'(opcode_out); c_cls = int'(class_out);
        c_ea = int'(ea_out); c_opf = int'(op_field);
      end
      if (k < 6) @(negedge clk);
    end

    chk(done_cnt == 1, collide ? "R7 single completion under busy start" : "R6 done pulse count", done_cnt, 1);
    chk(done_k == e_k, ind ? "R4 done cycle" : "R3 done cycle", done_k, e_k);
    chk(rd_cnt == (ind ? 1 : 0), ind ? "R4 read count" : "R5 R3 no read", rd_cnt, ind ? 1 : 0);
    if (ind) begin
      chk(rd_a == int'(a) && rd_k == 0, "R4 read address and cycle", rd_a, int'(a));
    end
    chk(c_opc == int'(opc), "R2 opcode", c_opc, int'(opc));
    chk(c_cls == e_cls, "R2 class", c_cls, e_cls);
    chk(c_ea == e_ea, is_mem ? (ind ? "R4 ea" : "R3 ea") : "R5 ea", c_ea, e_ea);
    chk(c_opf == e_opf, "R5 op_field", c_opf, e_opf);
    chk(int'(ea_out) == e_ea && int'(op_field) == e_opf && int'(class_out) == e_cls,
        "R8 outputs held", int'(ea_out), e_ea);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && mem_rd_en == 1'b0, "R1 strobes in reset", int'({done, mem_rd_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && mem_rd_en == 1'b0, "R1 strobes after reset", int'({done, mem_rd_en}), 0);
    chk(ea_out == '0 && op_field == '0, "R1 address outputs", int'({ea_out, op_field}), 0);
    chk(opcode_out == '0 && class_out == '0, "R1 class outputs", int'({opcode_out, class_out}), 0);

    for (int fb = 0; fb < 2; fb++) begin
      for (int op = 0; op < 8; op++) begin
        for (int ai = 0; ai < 4; ai++) begin
          run_insn({1'(fb), 3'(op), addr_pick(ai)}, 1'b0);
        end
      end
    end

    run_insn(16'hA123, 1'b1);
    run_insn(16'hE0FF, 1'b1);
    run_insn(16'h7F00, 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule